// File: doc/BRIEF.md
# LIFO Register Stack with Full and Empty Status

This block is a last-in, first-out store of 64 words held in a register file. A 6-bit pointer names the top entry. Each push moves the pointer up by one and then writes the input word at the new pointer. Each pop first copies the word at the pointer into an output register and then moves the pointer down by one. The first push after reset therefore writes location 1. Location 0 receives the 64th word, which is also the write that wraps the pointer back to zero.

There is no comparison against a depth count. The block sets the FULL flag when a push wraps the pointer to zero, and sets the EMPTY flag when a pop brings the pointer down to zero. Three kinds of request are refused: a push while FULL is set, a pop while EMPTY is set, and a push and pop in the same cycle. A refused request changes no state. It raises an error pulse in the following cycle.

All outputs come from registers and update on the clock edge that accepts a request. Push and pop are level strobes that are sampled once per cycle.

Top module: `reg_stack`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the pointer is 0, EMPTY is 1, FULL is 0, the error output is 0 and the data output is 0. Reset is synchronous and active high.
- R2: An accepted push sets the pointer to its old value plus one, modulo 64, and stores the input word at that new pointer. The first push after reset gives a pointer of 1.
- R3: An accepted push always clears EMPTY. It sets FULL exactly when the new pointer is 0, which is on the 64th push after an empty stack.
- R4: An accepted pop loads the data output with the word stored at the current pointer and sets the pointer to its old value minus one, modulo 64.
- R5: An accepted pop always clears FULL. It sets EMPTY exactly when the new pointer is 0.
- R6: A push while FULL is 1 is refused. The pointer, the flags, the stored words and the data output are unchanged, and the error output is 1 in the next cycle.
- R7: A pop while EMPTY is 1 is refused. The pointer, the flags and the data output are unchanged, and the error output is 1 in the next cycle.
- R8: When push and pop are both high in the same cycle, neither is performed and the error output is 1 in the next cycle. This applies whatever the flags are.
- R9: The data output holds its value in every cycle that has no accepted pop.
- R10: The error output is registered. It is 1 for exactly one cycle per refused request, and it is 0 after any cycle with an accepted request or with no request.
- R11: The stack holds 64 words. After 64 pushes from empty, 64 pops return those words in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Request to push `din` this cycle |
| pop | input | 1 | Request to pop the top word this cycle |
| din | input | DATA_W (8) | Word to be pushed |
| dout | output | DATA_W (8) | Last word that was successfully popped |
| full | output | 1 | FULL flag: set when the pointer has wrapped to 0 on a push |
| empty | output | 1 | EMPTY flag: set when the pointer has returned to 0 on a pop |
| sp | output | PTR_W (6) | Current stack pointer |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench fills the stack to the wrap point. A design that compares the pointer against 63, or that writes before it increments, would raise FULL one push early, or it would overwrite a live word, and the reverse-order drain would then return a wrong or missing word. The bench pushes into a full stack and pops from an empty one. A design that does not guard these cases would move the pointer through zero and corrupt the flags. The bench also drives push and pop together, repeats refusals back to back, and follows them with an accepted request. This shows whether the error pulse is dropped, whether it sticks high, or whether a dual request is wrongly carried out as one of the two operations. Idle cycles between pops check that the data output is held and not re-read.

// File: rtl/stk_pkg.sv
package stk_pkg;

    // Decoded request for the current cycle.
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_PUSH   = 2'd1,
        OP_POP    = 2'd2,
        OP_REFUSE = 2'd3
    } stk_op_e;

    // The two status flags, kept together in one register.
    typedef struct packed {
        logic full;
        logic empty;
    } stk_flags_t;

    localparam stk_flags_t FLAGS_RESET = '{full: 1'b0, empty: 1'b1};

    // Turns the strobes and the present flags into one operation.
    function automatic stk_op_e classify(input logic push, input logic pop,
                                         input logic full, input logic empty);
        if (push && pop) return OP_REFUSE;
        if (push)        return full  ? OP_REFUSE : OP_PUSH;
        if (pop)         return empty ? OP_REFUSE : OP_POP;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl
    import stk_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    output stk_op_e          op_o,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);

    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_ZERO = '0;

    logic [PTR_W-1:0] sp_q;
    logic [PTR_W-1:0] sp_up;
    logic [PTR_W-1:0] sp_dn;
    stk_flags_t       flags_q;
    logic             err_q;
    stk_op_e          op;

    assign sp_up = sp_q + PTR_ONE;
    assign sp_dn = sp_q - PTR_ONE;
    assign op    = classify(push_i, pop_i, flags_q.full, flags_q.empty);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q    <= PTR_ZERO;
            flags_q <= FLAGS_RESET;
            err_q   <= 1'b0;
        end else begin
            err_q <= (op == OP_REFUSE);
            case (op)
                OP_PUSH: begin
                    sp_q          <= sp_up;
                    flags_q.full  <= (sp_up == PTR_ZERO);
                    flags_q.empty <= 1'b0;
                end
                OP_POP: begin
                    sp_q          <= sp_dn;
                    flags_q.empty <= (sp_dn == PTR_ZERO);
                    flags_q.full  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign op_o      = op;
    assign sp_o      = sp_q;
    assign wr_addr_o = sp_up;
    assign full_o    = flags_q.full;
    assign empty_o   = flags_q.empty;
    assign err_o     = err_q;

    // R1: the two flags are never both set
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(flags_q.full && flags_q.empty));

    a_r3_push_moves_up: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) |=> (!flags_q.empty && sp_q == $past(sp_q) + PTR_ONE));

    a_r5_pop_moves_down: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP) |=> (!flags_q.full && sp_q == $past(sp_q) - PTR_ONE));

    a_r6_full_push_refused: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && flags_q.full) |=> (err_q && $stable(sp_q) && flags_q.full));

    a_r7_empty_pop_refused: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && flags_q.empty) |=> (err_q && $stable(sp_q) && flags_q.empty));

    a_r8_dual_refused: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> (err_q && $stable(sp_q) && $stable(flags_q)));

    a_r10_err_clear: assert property (@(posedge clk) disable iff (rst)
        (op != OP_REFUSE) |=> !err_q);

endmodule

// File: rtl/stk_storage.sv
module stk_storage #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [PTR_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_q <= '0;
        else if (re_i) rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;

    // R9: the output register changes only on an accepted pop
    a_r9_dout_hold: assert property (@(posedge clk) disable iff (rst)
        !re_i |=> $stable(rdata_q));

endmodule

// File: rtl/reg_stack.sv
module reg_stack
    import stk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic [PTR_W-1:0]  sp,
    output logic              err
);

    stk_op_e          op;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] sp_int;

    stk_ptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_i   (push),
        .pop_i    (pop),
        .op_o     (op),
        .sp_o     (sp_int),
        .wr_addr_o(wr_addr),
        .full_o   (full),
        .empty_o  (empty),
        .err_o    (err)
    );

    stk_storage #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we_i   (op == OP_PUSH),
        .waddr_i(wr_addr),
        .wdata_i(din),
        .re_i   (op == OP_POP),
        .raddr_i(sp_int),
        .rdata_o(dout)
    );

    assign sp = sp_int;

endmodule

// File: tb/tb_reg_stack.sv
`timescale 1ns/1ps
module tb_reg_stack;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push = 1'b0;
    logic       pop = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       full, empty, err;
    logic [5:0] sp;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model: a queue of live words plus the last popped value
    logic [7:0] q[$];
    logic [7:0] m_dout = '0;
    bit         m_err  = 0;

    always #2.5 clk = ~clk;

    reg_stack dut (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .din(din),
        .dout(dout), .full(full), .empty(empty), .sp(sp), .err(err)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "sp",    sp,    q.size() % 64);
        check(tag, "full",  full,  q.size() == 64);
        check(tag, "empty", empty, q.size() == 0);
        check(tag, "err",   err,   m_err);
        check(tag, "dout",  dout,  m_dout);
    endtask

    // one cycle: drive, clock, update model, compare after the edge
    task automatic step(input bit p, input bit o, input logic [7:0] d, input string tag);
        bit was_full, was_empty;
        push = p; pop = o; din = d;
        was_full  = (q.size() == 64);
        was_empty = (q.size() == 0);
        @(posedge clk);
        m_err = (p && o) || (p && was_full) || (o && was_empty);
        if (!m_err && p) q.push_back(d);
        if (!m_err && o) begin m_dout = q[$]; q.pop_back(); end
        #1;
        compare(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare("R1 in reset");
        rst = 1'b0;
        @(posedge clk); #1;
        compare("R1 after release");

        // R7: pop from empty, twice in a row (R10 repeated pulse)
        step(0, 1, 8'h00, "R7 pop empty");
        step(0, 1, 8'h00, "R7 R10 pop empty again");
        step(0, 0, 8'h00, "R10 pulse ends");

        // R2 first push lands at pointer 1; R4 LIFO order; R9 hold
        step(1, 0, 8'h11, "R2 first push");
        step(1, 0, 8'h22, "R2 push");
        step(1, 0, 8'h33, "R2 push");
        step(1, 1, 8'h44, "R8 dual request");
        step(1, 0, 8'h55, "R10 accepted after refuse");
        step(0, 1, 8'h00, "R4 pop");
        step(0, 0, 8'h00, "R9 hold");
        step(0, 0, 8'h00, "R9 hold");
        step(0, 1, 8'h00, "R4 pop");
        step(1, 1, 8'h00, "R8 dual request");
        step(0, 1, 8'h00, "R4 pop");
        step(0, 1, 8'h00, "R5 pop to empty");
        step(0, 1, 8'h00, "R7 pop empty");
        step(1, 1, 8'h99, "R8 dual when empty");

        // R3 R11: fill to the wrap point
        for (int i = 0; i < 64; i++)
            step(1, 0, 8'(i * 7 + 3), "R3 R11 fill");
        step(1, 0, 8'hEE, "R6 push full");
        step(1, 0, 8'hEF, "R6 R10 push full again");
        step(1, 1, 8'hF0, "R8 dual when full");
        step(0, 0, 8'h00, "R9 hold when full");
        step(0, 1, 8'h00, "R5 pop clears full");
        step(1, 0, 8'hA5, "R3 refill to full");
        step(1, 0, 8'h5A, "R6 push full");

        // R11: drain in reverse order
        for (int i = 0; i < 64; i++)
            step(0, 1, 8'h00, "R11 R5 drain");
        step(0, 1, 8'h00, "R7 pop after drain");

        // mixed pattern
        for (int i = 0; i < 200; i++)
            step(((i * 5) % 3) != 0, ((i * 11) % 4) == 1, 8'(i * 13 + 1), "R2 R4 mixed");

        // R1: reset in mid-use
        rst = 1'b1;
        @(posedge clk); #1;
        q.delete(); m_dout = '0; m_err = 0;
        compare("R1 reset mid-use");
        rst = 1'b0;
        step(1, 0, 8'h77, "R2 push after reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule